// File: doc/BRIEF.md
# HDLC Transmit Framer with Automatic Frame Control

This block turns a stream of host bytes into bit-oriented HDLC/SDLC frames on one serial line. It sends one bit for each pulse of a bit-clock enable. The host offers bytes through a valid/ready handshake into a one-byte holding register. The framer then handles the whole frame on its own. It sends the opening flag and presets the CRC. It inserts zeros in the body and CRC. When the holding register runs dry, it closes the frame with the complemented CRC and a closing flag. The host never has to step in between frames.

An underrun/end-of-message latch is set when a frame is closed because no byte was waiting. The latch clears by itself as soon as the next frame begins. The line can be sent plain (NRZ) or NRZI encoded. Between frames it idles either with marks or with back-to-back flags; in NRZI mode it is held high after the closing flag. A request-to-send output follows the host's request. When the host withdraws the request during a frame, the output stays up until the last bit of the closing flag has spent its full bit period on the line. An abort request ends the frame at once with a run of ones.

Top module: `hdlc_tx_framer`

## Requirements
- R1: The first byte written while idle starts a frame, which opens with the flag 0x7E, sent least significant bit first (bit order 0,1,1,1,1,1,1,0). The frame ends with the same flag after the CRC. Data bytes go out least significant bit first.
- R2: Inside the body and the CRC, a 0 is inserted after any run of five consecutive 1 bits, including a run that finishes on the last CRC bit. Flags, abort bits and idle bits are never stuffed.
- R3: The CRC is the 16-bit CCITT code (x^16+x^12+x^5+1) computed least significant bit first over the unstuffed data bits. It is preset to all ones automatically at each frame start, and its ones-complement is sent least significant bit first just before the closing flag.
- R4: If the holding register is empty when the last bit of a byte leaves, the framer treats this as underrun and sends the CRC and the closing flag. If a byte is waiting, it is sent next with no gap.
- R5: The latch output `eom` rises when a frame is closed by underrun. It returns to 0 in the bit slot where the next frame's opening flag starts. Reset value is 0.
- R6: In NRZ mode, the idle line after a frame is continuous 1s when `idle_mark`=1, and back-to-back 0x7E flags when `idle_mark`=0.
- R7: With `nrzi_en`=1, a 0 bit toggles the line and a 1 bit holds it. Every idle bit slot after the closing flag drives the line high, whatever the value of `idle_mark`.
- R8: `rts_out` rises on the clock after `rts_req` is high. When `rts_req` is low, `rts_out` stays high through the whole frame. It falls in the first bit slot after the closing flag's last bit has been on the line.
- R9: An abort request during a frame makes the line send eight 1 bits from the next bit slot. The frame then ends without CRC or closing flag, and the line returns to idle.
- R10: `tx_ready` is high exactly when the holding register is empty. Each handshake loads one byte and drops `tx_ready` on the next clock. After reset: `txd`=1, `rts_out`=0, `tx_ready`=1, `eom`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse marking each bit slot |
| tx_valid | input | 1 | Host offers a byte |
| tx_data | input | 8 | Byte offered by the host |
| tx_ready | output | 1 | Holding register empty |
| abort_req | input | 1 | Request to abort the current frame |
| nrzi_en | input | 1 | 1 = NRZI line code, 0 = NRZ |
| idle_mark | input | 1 | NRZ idle fill: 1 = marks, 0 = flags |
| rts_req | input | 1 | Host request-to-send |
| rts_out | output | 1 | Request-to-send delivered to the line |
| txd | output | 1 | Serial data line |
| eom | output | 1 | Underrun/end-of-message latch |

## Verification
Two functions can land on the same bit-slot boundary here. The closing of one frame (CRC output, then closing flag, plus the latch set by underrun) meets the opening of the next (CRC preset, latch clear, opening flag). The bench provokes this by writing the next frame's first byte right after the latch rises, while the first frame's CRC is still going out. The decoded line must then show the closing flag followed directly by a new opening flag, a second body whose CRC is correct only if the preset really happened, and a latch that has cleared again. A withdrawn send request is judged against the same boundary: `rts_out` must still be high on the final flag bit and low in the slot after it.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_DATA,
      ST_CRC,
      ST_CLOSE,
      ST_ABORT
   } tx_state_e;

   localparam logic [7:0] FLAG_BYTE = 8'h7E;
endpackage

// File: rtl/hdlc_hold_reg.sv
module hdlc_hold_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   input  logic         take,
   output logic         in_ready,
   output logic         full,
   output logic [W-1:0] q
);
   logic         full_q;
   logic [W-1:0] data_q;

   assign in_ready = ~full_q;
   assign full     = full_q;
   assign q        = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (take) full_q <= 1'b0;
         if (in_valid && !full_q) begin
            full_q <= 1'b1;
            data_q <= in_data;
         end
      end
   end
endmodule

// File: rtl/hdlc_crc_gen.sv
module hdlc_crc_gen #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   POLY = 16'h8408
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         preset,
   input  logic         upd,
   input  logic         din,
   input  logic         shift,
   output logic [W-1:0] crc
);
   logic [W-1:0] crc_q;
   logic         fb;

   assign crc = crc_q;
   assign fb  = crc_q[0] ^ din;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= '1;
      end else if (preset) begin
         crc_q <= '1;
      end else if (upd) begin
         crc_q <= (crc_q >> 1) ^ (fb ? POLY : '0);
      end else if (shift) begin
         crc_q <= crc_q >> 1;
      end
   end
endmodule

// File: rtl/hdlc_line_enc.sv
module hdlc_line_enc #(
   parameter bit NRZI_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic raw,
   input  logic nrzi_en,
   input  logic force_high,
   output logic line
);
   logic lvl_q;
   logic lvl_d;

   assign line = lvl_q;

   generate
      if (NRZI_SUPPORT) begin : g_nrzi
         always_comb begin
            if (force_high)   lvl_d = 1'b1;
            else if (nrzi_en) lvl_d = raw ? lvl_q : ~lvl_q;
            else              lvl_d = raw;
         end
      end else begin : g_nrz_only
         always_comb lvl_d = raw | (force_high & nrzi_en);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      lvl_q <= 1'b1;
      else if (bit_en) lvl_q <= lvl_d;
   end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int               BYTE_W       = 8,
   parameter int               CRC_W        = 16,
   parameter logic [CRC_W-1:0] CRC_POLY     = 16'h8408,
   parameter int               STUFF_RUN    = 5,
   parameter int               ABORT_ONES   = 8,
   parameter bit               NRZI_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              tx_valid,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              tx_ready,
   input  logic              abort_req,
   input  logic              nrzi_en,
   input  logic              idle_mark,
   input  logic              rts_req,
   output logic              rts_out,
   output logic              txd,
   output logic              eom
);
   localparam int CNT_MAX = (CRC_W > ABORT_ONES) ? CRC_W : ABORT_ONES;
   localparam int CNT_W   = $clog2(CNT_MAX);
   localparam int RUN_W   = $clog2(STUFF_RUN + 1);

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("flag pattern needs 8-bit bytes");
      end
      if (CRC_W < 8) begin : g_bad_crc
         $error("CRC width too small");
      end
      if (ABORT_ONES < 7) begin : g_bad_abort
         $error("abort needs at least seven ones");
      end
      if (STUFF_RUN < 1) begin : g_bad_run
         $error("stuff run must be positive");
      end
   endgenerate

   tx_state_e         state_q, state_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [BYTE_W-1:0] sh_q, sh_d;
   logic [RUN_W-1:0]  ones_q, ones_d;
   logic [2:0]        idle_q, idle_d;
   logic              abort_q, abort_d;
   logic              eom_q, eom_d;
   logic              rts_q, rts_d;

   logic              raw_bit, force_high, take;
   logic              crc_preset, crc_upd, crc_shift;
   logic              hold_full;
   logic [BYTE_W-1:0] hold_q;
   logic [CRC_W-1:0]  crc_q;
   logic              in_frame, stuff_now;

   hdlc_hold_reg #(.W(BYTE_W)) hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (tx_valid),
      .in_data  (tx_data),
      .take     (take),
      .in_ready (tx_ready),
      .full     (hold_full),
      .q        (hold_q)
   );

   hdlc_crc_gen #(.W(CRC_W), .POLY(CRC_POLY)) crc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .preset (crc_preset),
      .upd    (crc_upd),
      .din    (sh_q[0]),
      .shift  (crc_shift),
      .crc    (crc_q)
   );

   hdlc_line_enc #(.NRZI_SUPPORT(NRZI_SUPPORT)) enc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .raw        (raw_bit),
      .nrzi_en    (nrzi_en),
      .force_high (force_high),
      .line       (txd)
   );

   assign in_frame  = (state_q == ST_OPEN) || (state_q == ST_DATA) ||
                      (state_q == ST_CRC)  || (state_q == ST_CLOSE);
   assign stuff_now = (ones_q == RUN_W'(STUFF_RUN)) &&
                      ((state_q == ST_DATA) || (state_q == ST_CRC) || (state_q == ST_CLOSE));
   assign eom       = eom_q;
   assign rts_out   = rts_q;

   always_comb begin
      state_d    = state_q;
      cnt_d      = cnt_q;
      sh_d       = sh_q;
      ones_d     = ones_q;
      idle_d     = idle_q;
      eom_d      = eom_q;
      abort_d    = abort_q | (abort_req & in_frame);
      raw_bit    = 1'b1;
      force_high = 1'b0;
      take       = 1'b0;
      crc_preset = 1'b0;
      crc_upd    = 1'b0;
      crc_shift  = 1'b0;
      if (bit_en) begin
         ones_d = '0;
         if (abort_q && in_frame) begin
            state_d = ST_ABORT;
            cnt_d   = CNT_W'(1);
            abort_d = 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (hold_full && (idle_mark || nrzi_en || idle_q == 3'd0)) begin
                     raw_bit    = FLAG_BYTE[0];
                     state_d    = ST_OPEN;
                     cnt_d      = CNT_W'(1);
                     crc_preset = 1'b1;
                     eom_d      = 1'b0;
                  end else begin
                     force_high = nrzi_en;
                     raw_bit    = idle_mark ? 1'b1 : FLAG_BYTE[idle_q];
                     idle_d     = idle_q + 3'd1;
                  end
               end
               ST_OPEN: begin
                  raw_bit = FLAG_BYTE[cnt_q[2:0]];
                  if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                     take    = 1'b1;
                     sh_d    = hold_q;
                     state_d = ST_DATA;
                     cnt_d   = '0;
                  end else begin
                     cnt_d = cnt_q + CNT_W'(1);
                  end
               end
               ST_DATA: begin
                  if (stuff_now) begin
                     raw_bit = 1'b0;
                  end else begin
                     raw_bit = sh_q[0];
                     crc_upd = 1'b1;
                     ones_d  = sh_q[0] ? ones_q + RUN_W'(1) : '0;
                     sh_d    = sh_q >> 1;
                     if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                        cnt_d = '0;
                        if (hold_full) begin
                           take = 1'b1;
                           sh_d = hold_q;
                        end else begin
                           state_d = ST_CRC;
                           eom_d   = 1'b1;
                        end
                     end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                     end
                  end
               end
               ST_CRC: begin
                  if (stuff_now) begin
                     raw_bit = 1'b0;
                  end else begin
                     raw_bit   = ~crc_q[0];
                     crc_shift = 1'b1;
                     ones_d    = ~crc_q[0] ? ones_q + RUN_W'(1) : '0;
                     if (cnt_q == CNT_W'(CRC_W - 1)) begin
                        state_d = ST_CLOSE;
                        cnt_d   = '0;
                     end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                     end
                  end
               end
               ST_CLOSE: begin
                  if (stuff_now) begin
                     raw_bit = 1'b0;
                  end else begin
                     raw_bit = FLAG_BYTE[cnt_q[2:0]];
                     if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                        idle_d  = 3'd0;
                        abort_d = 1'b0;
                     end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                     end
                  end
               end
               ST_ABORT: begin
                  if (cnt_q == CNT_W'(ABORT_ONES - 1)) begin
                     state_d = ST_IDLE;
                     cnt_d   = '0;
                     idle_d  = 3'd0;
                     abort_d = 1'b0;
                  end else begin
                     cnt_d = cnt_q + CNT_W'(1);
                  end
               end
               default: state_d = ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      if (rts_req)                          rts_d = 1'b1;
      else if (bit_en && state_q == ST_IDLE) rts_d = 1'b0;
      else                                   rts_d = rts_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         ones_q  <= '0;
         idle_q  <= '0;
         abort_q <= 1'b0;
         eom_q   <= 1'b0;
         rts_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         sh_q    <= sh_d;
         ones_q  <= ones_d;
         idle_q  <= idle_d;
         abort_q <= abort_d;
         eom_q   <= eom_d;
         rts_q   <= rts_d;
      end
   end
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
   import hdlc_tx_pkg::*;
#(
   parameter int RUN_W     = 3,
   parameter int STUFF_RUN = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic             nrzi_en,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             rts_req,
   input logic             rts_out,
   input logic             txd,
   input logic             eom,
   input tx_state_e        state,
   input logic [RUN_W-1:0] ones_cnt
);
   // R10
   accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !tx_ready);

   // R5
   eom_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eom) |-> state == ST_CRC);

   // R8
   rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rts_req |=> rts_out);

   // R8
   rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rts_out && state != ST_IDLE |=> rts_out);

   // R7
   nrzi_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nrzi_en && bit_en && state == ST_IDLE |=> txd || state == ST_OPEN);

   // R9
   abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nrzi_en && bit_en && state == ST_ABORT |=> txd);

   // R2
   run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ones_cnt <= RUN_W'(STUFF_RUN));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.RUN_W(RUN_W), .STUFF_RUN(STUFF_RUN)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .nrzi_en  (nrzi_en),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .rts_req  (rts_req),
   .rts_out  (rts_out),
   .txd      (txd),
   .eom      (eom),
   .state    (state_q),
   .ones_cnt (ones_q)
);

// File: tb/hdlc_tx_framer_tb_top.sv
module hdlc_tx_framer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_DIV    = 4;
   localparam int REC_MAX    = 2048;
   localparam logic [7:0] FLAG = 8'h7E;

   logic       clk, rst_n, bit_en, tx_valid, tx_ready, abort_req;
   logic       nrzi_en, idle_mark, rts_req, rts_out, txd, eom;
   logic [7:0] tx_data;

   int checks = 0;
   int fails  = 0;
   int ph     = 0;

   logic rec_line [0:REC_MAX-1];
   logic rec_rts  [0:REC_MAX-1];
   logic dec      [0:REC_MAX-1];
   logic exp_bits [0:REC_MAX-1];
   int   rec_n = 0;
   int   exp_n = 0;
   logic rec_pre = 1'b1;
   logic [7:0] fb [0:7];

   hdlc_tx_framer dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .abort_req(abort_req),
      .nrzi_en(nrzi_en), .idle_mark(idle_mark), .rts_req(rts_req),
      .rts_out(rts_out), .txd(txd), .eom(eom)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      if (bit_en && rec_n < REC_MAX) begin
         rec_line[rec_n] = txd;
         rec_rts[rec_n]  = rts_out;
         rec_n = rec_n + 1;
      end
      ph = ph + 1;
      bit_en = rst_n && (ph % BIT_DIV == 0);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      finish_run();
   end

   task automatic clear_rec();
      rec_n   = 0;
      rec_pre = txd;
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = b;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic push_bit(input logic b);
      exp_bits[exp_n] = b;
      exp_n++;
   endtask

   task automatic push_flag();
      for (int i = 0; i < 8; i++) push_bit(FLAG[i]);
   endtask

   task automatic push_body(input int first, input int n);
      logic [15:0] crc;
      int ones;
      crc  = 16'hFFFF;
      ones = 0;
      for (int k = 0; k < n + 2; k++) begin
         logic [7:0] byt;
         if (k < n) byt = fb[first + k];
         for (int i = 0; i < 8; i++) begin
            logic b;
            if (k < n) begin
               b = byt[i];
               crc = (crc >> 1) ^ (((crc[0] ^ b) == 1'b1) ? 16'h8408 : 16'h0000);
            end else begin
               b = ~crc[(k - n) * 8 + i];
            end
            push_bit(b);
            ones = b ? ones + 1 : 0;
            if (ones == 5) begin
               push_bit(1'b0);
               ones = 0;
            end
         end
         if (k == n - 1) crc = crc;
      end
   endtask

   task automatic decode(input bit nz);
      logic prev;
      prev = rec_pre;
      for (int i = 0; i < rec_n; i++) begin
         dec[i] = nz ? (rec_line[i] == prev) : rec_line[i];
         prev   = rec_line[i];
      end
   endtask

   function automatic int find_exp();
      for (int off = 0; off + exp_n <= rec_n; off++) begin
         bit hit;
         hit = 1'b1;
         for (int j = 0; j < exp_n; j++)
            if (dec[off + j] !== exp_bits[j]) hit = 1'b0;
         if (hit) return off;
      end
      return -1;
   endfunction

   function automatic logic [7:0] pat_byte(input int f, input int k);
      case (f)
         0: pat_byte = 8'hA5;
         1: pat_byte = 8'hFF;
         2: pat_byte = (k == 0) ? 8'h7E : ((k == 1) ? 8'h00 : 8'h1F);
         default: pat_byte = (k == 0) ? 8'hF8 : ((k == 1) ? 8'h3E : ((k == 2) ? 8'hFF : 8'h01));
      endcase
   endfunction

   initial begin
      rst_n = 1'b0; bit_en = 1'b0; tx_valid = 1'b0; tx_data = 8'h00;
      abort_req = 1'b0; nrzi_en = 1'b0; idle_mark = 1'b1; rts_req = 1'b0;
      repeat (4) @(negedge clk);
      // R10: reset state
      chk(txd == 1'b1, "R10", "reset txd", txd, 1);
      chk(rts_out == 1'b0, "R10", "reset rts_out", rts_out, 0);
      chk(tx_ready == 1'b1, "R10", "reset tx_ready", tx_ready, 1);
      chk(eom == 1'b0, "R10", "reset eom", eom, 0);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);

      // R1 R2 R3 R4 R6 R7: sweep over line code, idle fill and frame pattern
      for (int nz = 0; nz < 2; nz++) begin
         for (int im = 0; im < 2; im++) begin
            for (int f = 0; f < 4; f++) begin
               int n, off, e;
               bit idle_ok;
               n = (f == 0) ? 1 : ((f == 1) ? 2 : ((f == 2) ? 3 : 4));
               nrzi_en   = nz[0];
               idle_mark = im[0];
               repeat (40 * BIT_DIV) @(negedge clk);
               clear_rec();
               for (int k = 0; k < n; k++) fb[k] = pat_byte(f, k);
               for (int k = 0; k < n; k++) send_byte(fb[k]);
               repeat (90 * BIT_DIV) @(negedge clk);
               exp_n = 0;
               push_flag();
               push_body(0, n);
               push_flag();
               decode(nz[0]);
               off = find_exp();
               chk(off >= 0, "R1/R2/R3/R4", $sformatf("frame nrzi=%0d idle=%0d pat=%0d", nz, im, f),
                   off, 0);
               if (off >= 0) begin
                  e = off + exp_n;
                  idle_ok = 1'b1;
                  for (int j = 0; j < 16; j++) begin
                     if (nz == 1) begin
                        if (rec_line[e + j] !== 1'b1) idle_ok = 1'b0;
                     end else if (im == 1) begin
                        if (dec[e + j] !== 1'b1) idle_ok = 1'b0;
                     end else begin
                        if (dec[e + j] !== FLAG[j % 8]) idle_ok = 1'b0;
                     end
                  end
                  chk(idle_ok, (nz == 1) ? "R7" : "R6",
                      $sformatf("idle after frame nrzi=%0d idle=%0d", nz, im), idle_ok, 1);
               end
            end
         end
      end

      // R8 / R10: RTS tracking and handshake
      begin
         int off, l;
         bit held;
         nrzi_en = 1'b0; idle_mark = 1'b1;
         repeat (20 * BIT_DIV) @(negedge clk);
         rts_req = 1'b1;
         @(negedge clk);
         chk(rts_out == 1'b1, "R8", "rts_out rise", rts_out, 1);
         clear_rec();
         fb[0] = 8'h81; fb[1] = 8'h42;
         send_byte(fb[0]);
         chk(tx_ready == 1'b0, "R10", "ready drops after accept", tx_ready, 0);
         send_byte(fb[1]);
         rts_req = 1'b0;
         repeat (80 * BIT_DIV) @(negedge clk);
         exp_n = 0;
         push_flag(); push_body(0, 2); push_flag();
         decode(1'b0);
         off = find_exp();
         chk(off >= 0, "R8", "frame with rts release", off, 0);
         if (off >= 0) begin
            l = off + exp_n - 1;
            held = 1'b1;
            for (int j = off; j <= l; j++) if (rec_rts[j] !== 1'b1) held = 1'b0;
            chk(held, "R8", "rts_out held through frame", held, 1);
            chk(rec_rts[l + 1] == 1'b0, "R8", "rts_out falls after closing flag",
                rec_rts[l + 1], 0);
         end
      end

      // R5 / R3: back-to-back frames, latch set then cleared, CRC preset again
      begin
         int off;
         clear_rec();
         fb[0] = 8'h12; fb[1] = 8'h34; fb[2] = 8'h56;
         send_byte(fb[0]);
         send_byte(fb[1]);
         chk(eom == 1'b0, "R5", "latch cleared at frame start", eom, 0);
         while (!eom) @(negedge clk);
         send_byte(fb[2]);
         @(negedge clk);
         while (!tx_ready) @(negedge clk);
         chk(eom == 1'b0, "R5", "latch cleared at second frame", eom, 0);
         repeat (80 * BIT_DIV) @(negedge clk);
         chk(eom == 1'b1, "R5", "latch set by underrun", eom, 1);
         exp_n = 0;
         push_flag(); push_body(0, 2); push_flag();
         push_flag(); push_body(2, 1); push_flag();
         decode(1'b0);
         off = find_exp();
         chk(off >= 0, "R3", "back-to-back frames with CRC preset", off, 0);
      end

      // R9: abort
      begin
         int idx, zeros;
         bit started;
         repeat (20 * BIT_DIV) @(negedge clk);
         clear_rec();
         send_byte(8'h00);
         repeat (14 * BIT_DIV) @(negedge clk);
         idx = rec_n;
         abort_req = 1'b1;
         @(negedge clk);
         abort_req = 1'b0;
         repeat (60 * BIT_DIV) @(negedge clk);
         started = 1'b0;
         for (int j = 0; j < idx; j++) if (rec_line[j] == 1'b0) started = 1'b1;
         chk(started, "R9", "frame began before abort", started, 1);
         zeros = 0;
         for (int j = idx + 2; j < rec_n; j++) if (rec_line[j] == 1'b0) zeros++;
         chk(zeros == 0, "R9", "no CRC or flag after abort", zeros, 0);
         chk(tx_ready == 1'b1, "R9", "idle after abort", tx_ready, 1);
      end

      finish_run();
   end
endmodule